// File: doc/BRIEF.md
# Pulse-Count Carrier Detector

This block decides whether a modem receiver is hearing a carrier. An analog threshold comparator outside the block gives one pulse for each received cycle whose amplitude clears the detect level. The block raises its carrier-detect flag once a run of consecutive pulses has arrived, with no gap of 2.5 ms or longer between any two of them. It keeps the flag up while each later pulse follows the one before within that window. It drops the flag when the pulses stop.

The flag only means something while the local transmitter is idle. The active-low request-to-send input therefore holds the flag low and discards any partial run. The block runs from the 460.8 kHz modem clock. Four pulses take about 3.33 ms at the 1200 Hz tone and about 1.82 ms at the 2200 Hz tone, so both tones qualify well inside the timeout.

Top module: `pulse_carrier_detect`

## Requirements
- R1: With rts_ni high, cd_o goes high after four consecutive rising edges of cmp_i. Three rising edges leave it low.
- R2: Once high, cd_o stays high while rts_ni stays high and each rising edge of cmp_i follows the previous one by fewer than 1152 clocks. A spacing of 1151 clocks still qualifies.
- R3: If two rising edges of cmp_i are 1152 or more clocks apart, the run is broken. If no rising edge is seen for 1152 clocks after the last one, the run is broken too: cd_o drops at the 1152nd clock edge after the edge on which that last pulse was counted, and the pulse count clears.
- R4: After cd_o has dropped, four new consecutive rising edges are needed to raise it again.
- R5: While rts_ni is low, cd_o is low from the next clock edge onward and the pulse count is held at zero. When rts_ni returns high, counting restarts from zero.
- R6: Only rising edges of cmp_i count. A pulse held high for many clocks counts once.
- R7: cmp_i passes through a two-flop synchronizer. cd_o rises on the second clock edge after the fourth rising edge is first sampled high at a clock edge.
- R8: rst_ni low clears cd_o, the pulse count and the gap timer asynchronously. The gap timer restarts in its expired state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 460.8 kHz modem clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Carrier comparator output, asynchronous, one pulse per qualifying cycle |
| rts_ni | input | 1 | Request to send, active low; low blocks detection |
| cd_o | output | 1 | Carrier-detect flag, active high |

## Verification
A rising edge of cmp_i that is first sampled high at edge k is counted at edge k+2, because of the two-flop synchronizer. The bench drives inputs on falling edges and reads cd_o on falling edges, so it can name the exact edge at which a result is due. The timeout is checked on both sides: cd_o is read one edge before and at the 1152nd edge after the counted pulse. The R7 latency is checked by reading cd_o after edge k+1 (still low) and after edge k+2 (high). The R5 gating is checked one edge after rts_ni falls. The table vectors start from idle, after a quiet period longer than the timeout. Each is read a full pulse period after its last pulse, long after the two-edge latency and well before any timeout.

// File: rtl/cd_pkg.sv
package cd_pkg;
  // clocks in a window of us microseconds
  function automatic int gap_clks(input int clk_hz, input int us);
    longint prod;
    prod = longint'(clk_hz) * longint'(us);
    return int'(prod / 64'd1000000);
  endfunction
endpackage

// File: rtl/cd_edge_sync.sv
module cd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R6: one edge report per low-to-high transition
  a_r6_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cd_gap_timer.sv
module cd_gap_timer #(
  parameter int GAP_CLKS = 1152
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic expired_o
);
  localparam int W = $clog2(GAP_CLKS);
  localparam logic [W-1:0] LIM = W'(GAP_CLKS - 1);

  logic [W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= LIM;
    else if (rise_i)        gap_q <= '0;
    else if (gap_q != LIM)  gap_q <= gap_q + 1'b1;
  end

  assign expired_o = (gap_q == LIM);

  // R3: timer restarts on each counted edge
  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (gap_q == '0));
  // R2: saturating, never runs past the window
  a_r2_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= LIM);
endmodule

// File: rtl/cd_run_counter.sv
module cd_run_counter #(
  parameter int PULSES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rts_ni,
  input  logic rise_i,
  input  logic expired_i,
  output logic cd_o
);
  localparam int CW = $clog2(PULSES + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSES);

  logic [CW-1:0] cnt_q, cnt_inc;
  logic          cd_q;

  // a pulse after an expired gap starts a fresh run
  always_comb begin
    if (expired_i)          cnt_inc = CW'(1);
    else if (cnt_q == FULL) cnt_inc = FULL;
    else                    cnt_inc = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cd_q  <= 1'b0;
    end else if (!rts_ni) begin
      cnt_q <= '0;
      cd_q  <= 1'b0;
    end else if (rise_i) begin
      cnt_q <= cnt_inc;
      cd_q  <= (cnt_inc == FULL);
    end else if (expired_i) begin
      cnt_q <= '0;
      cd_q  <= 1'b0;
    end
  end

  assign cd_o = cd_q;

  // R5: transmit request forces the flag low
  a_r5_rts_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_ni |=> !cd_q);
  // R1: flag only rises on a counted edge with rts idle
  a_r1_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cd_q) |-> ($past(rise_i) && $past(rts_ni)));
  // R3: quiet window drops the flag
  a_r3_timeout_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_i && !rise_i) |=> !cd_q);
  // R1: count saturates
  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
endmodule

// File: rtl/pulse_carrier_detect.sv
module pulse_carrier_detect #(
  parameter int CLK_HZ      = 460800,
  parameter int GAP_US      = 2500,
  parameter int PULSES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic rts_ni,
  output logic cd_o
);
  localparam int GAP_CLKS = cd_pkg::gap_clks(CLK_HZ, GAP_US);

  logic rise, expired;

  cd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cmp_i), .rise_o(rise));

  cd_gap_timer #(.GAP_CLKS(GAP_CLKS)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .expired_o(expired));

  cd_run_counter #(.PULSES(PULSES)) i_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .rts_ni(rts_ni), .rise_i(rise),
    .expired_i(expired), .cd_o(cd_o));
endmodule

// File: tb/test_pulse_carrier_detect.sv
module test_pulse_carrier_detect;
  logic clk = 1'b0, rst_ni = 1'b0, cmp = 1'b0, rts_n = 1'b1;
  logic cd;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_carrier_detect i_pulse_carrier_detect (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_i(cmp), .rts_ni(rts_n), .cd_o(cd));

  typedef struct packed {
    logic        rts;
    logic [11:0] per;
    logic [11:0] hi;
    logic [3:0]  n;
    logic        exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'd384,  12'd192, 4'd4, 1'b1},  // R1 1200 Hz
    '{1'b1, 12'd210,  12'd105, 4'd4, 1'b1},  // R1 2200 Hz
    '{1'b1, 12'd384,  12'd192, 4'd3, 1'b0},  // R1 three only
    '{1'b1, 12'd210,  12'd105, 4'd3, 1'b0},  // R1 three only
    '{1'b0, 12'd384,  12'd192, 4'd6, 1'b0},  // R5 rts active
    '{1'b1, 12'd1151, 12'd500, 4'd4, 1'b1},  // R2 just inside window
    '{1'b1, 12'd1152, 12'd500, 4'd6, 1'b0},  // R3 at window
    '{1'b1, 12'd8,    12'd4,   4'd4, 1'b1},  // R1 fast pulses
    '{1'b1, 12'd1152, 12'd500, 4'd1, 1'b0},  // R1 single pulse
    '{1'b1, 12'd600,  12'd599, 4'd3, 1'b0},  // R6 wide pulses
    '{1'b1, 12'd600,  12'd599, 4'd4, 1'b1}   // R6 wide pulses
  };

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: cd_o=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n pulses, one rising edge every per clocks; returns per clocks after last edge
  task automatic pulses(input int n, input int per, input int hi);
    for (int i = 0; i < n; i++) begin
      cmp = 1'b1;
      idle(hi);
      cmp = 1'b0;
      idle(per - hi);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: cd_o=%b expected run end", cd);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    check("R8 reset state", cd, 1'b0);
    rst_ni = 1'b1;
    idle(2);
    check("R8 after release", cd, 1'b0);

    for (int v = 0; v < NV; v++) begin
      rts_n = 1'b1; cmp = 1'b0;
      idle(1200);
      rts_n = VEC[v].rts;
      pulses(int'(VEC[v].n), int'(VEC[v].per), int'(VEC[v].hi));
      check($sformatf("R1/R2/R3/R5/R6 vector %0d", v), cd, VEC[v].exp);
    end
    rts_n = 1'b1;
    idle(1200);

    // R7: latency of two edges
    pulses(3, 100, 50);
    cmp = 1'b1;            // sampled at edge k
    @(negedge clk);        // after k
    @(negedge clk);        // after k+1
    check("R7 not yet after k+1", cd, 1'b0);
    @(negedge clk);        // after k+2
    check("R7 high after k+2", cd, 1'b1);
    cmp = 1'b0;

    // R2: held by pulses spaced 1100 clocks
    idle(97);
    pulses(8, 1100, 300);
    check("R2 held", cd, 1'b1);

    // R3: exact drop edge; last edge sampled at k, counted at k+2
    pulses(1, 100, 50);    // now after edge k+99
    idle(1054);            // after k+1153
    check("R3 still high", cd, 1'b1);
    idle(1);               // after k+1154
    check("R3 dropped", cd, 1'b0);

    // R4: fresh run needed
    pulses(3, 200, 100);
    check("R4 three after drop", cd, 1'b0);
    pulses(1, 200, 100);
    check("R4 fourth after drop", cd, 1'b1);

    // R5: rts gating
    rts_n = 1'b0;
    idle(1);
    check("R5 one edge after rts", cd, 1'b0);
    idle(20);
    rts_n = 1'b1;
    pulses(3, 200, 100);
    check("R5 count restarted", cd, 1'b0);
    pulses(1, 200, 100);
    check("R5 four after rts", cd, 1'b1);

    // R8: async reset mid carrier
    #1 rst_ni = 1'b0;
    #1 check("R8 async clear", cd, 1'b0);
    idle(2);
    rst_ni = 1'b1;
    pulses(3, 200, 100);
    check("R8 count cleared", cd, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule